// File: doc/BRIEF.md
# Sixteen-bit ALU with condition-flag update

This block is the arithmetic and logic unit of a small sixteen-bit processor datapath. It is purely combinational. It takes an operation code, two operands and the current negative, zero, carry and overflow flags. In the same cycle it returns the result, the next value of the flags and a write strobe for the destination register. The register file, the instruction decoder and memory are outside the block. The decoder sets the operands: for example, it feeds the immediate into the second operand for the immediate move and the immediate compare.

Each operation changes only its own set of flags and passes the other flags through unchanged. Because of this, the flag register outside can be loaded unconditionally every cycle. Compare and negate report carry in the "no borrow" sense, so a subtraction that does not wrap sets C. The arithmetic shift right reads its amount from the low byte of the second operand. An amount of zero and an amount of sixteen or more are handled as special cases.

Top module: `alu16_core`

## Requirements
- R1: Flags are packed as {N,Z,C,V} in bits 3..0. Whenever an operation updates N, N equals result bit 15, except in R9. Whenever it updates Z, Z is 1 exactly when the 16-bit result is zero.
- R2: Add (code 0) returns a+b modulo 2^16. C is the carry out, V is set on signed overflow, and N and Z follow R1.
- R3: Compare (code 6) returns a-b, and negate (code 5) returns 0-b. In both, C is 1 when the subtraction does not borrow, V is set on signed overflow of the subtraction, and N and Z follow R1.
- R4: And (code 1), xor (code 2), test (code 4, returns a AND b) and register move (code 7, returns b) update only N and Z. C and V pass through unchanged.
- R5: Arithmetic shift right (code 3) with a shift amount b[7:0] from 1 to 15 returns a shifted with sign fill. C becomes bit (amount-1) of a.
- R6: Arithmetic shift right with b[7:0] equal to 0 returns a unchanged and leaves C unchanged. Bits b[15:8] are ignored, so b=0x0100 acts as zero.
- R7: Arithmetic shift right with b[7:0] of 16 or more returns 0x0000 or 0xFFFF, a copy of a[15] in every bit. C becomes a[15].
- R8: Arithmetic shift right never changes V.
- R9: Immediate move (code 8) returns b, forces N to 0, sets Z from b, and leaves C and V unchanged.
- R10: The write strobe is 0 for compare (6), test (4) and every unassigned code (9 to 15). It is 1 for all other codes.
- R11: Unassigned codes (9 to 15) return result 0 and leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand (destination register value) |
| b_i | input | 16 | Second operand (source register or immediate) |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 16 | Operation result |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| wr_en_o | output | 1 | Destination register write strobe |

## Verification
The bench aims directed vectors at the points where the carry sense matters:

- **Subtraction carry.** Comparing equal values and computing 0-1 expose a design that uses borrow polarity for C, because the carry bit comes out inverted in both cases.
- **Signed overflow.** Adding across 0x7FFF and negating 0x8000 catch an overflow term built from the wrong sign bits.
- **Shift edge amounts.** Amounts 0, 1, 15, 16 and 255, and an amount of 0x0100 whose low byte is zero, catch several faults. These include a shifter that reads the whole operand, one that wraps the amount modulo 16, and one that clobbers C on a zero shift.
- **Random mix.** Random operations over all sixteen codes catch any operation that touches a flag outside its own set, or that writes back on compare, test or an unassigned code.

// File: rtl/alu16_pkg.sv
`timescale 1ns/1ps
package alu16_pkg;

   // operation codes
   localparam logic [3:0] OP_ADD  = 4'd0;
   localparam logic [3:0] OP_AND  = 4'd1;
   localparam logic [3:0] OP_EOR  = 4'd2;
   localparam logic [3:0] OP_ASR  = 4'd3;
   localparam logic [3:0] OP_TST  = 4'd4;
   localparam logic [3:0] OP_NEG  = 4'd5;
   localparam logic [3:0] OP_CMP  = 4'd6;
   localparam logic [3:0] OP_MOV  = 4'd7;
   localparam logic [3:0] OP_MOVI = 4'd8;

   // flag positions inside the 4-bit flag vector
   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;

   typedef enum logic [1:0] {
      CSRC_ADDER = 2'd0,
      CSRC_SHIFT = 2'd1,
      CSRC_HOLD  = 2'd2
   } carry_src_e;

   typedef struct packed {
      logic       wr;        // destination write strobe
      logic [3:0] upd;       // per-flag update mask {N,Z,C,V}
      logic       force_n0;  // N forced to zero
      carry_src_e csrc;      // where a new C comes from
   } flag_ctl_t;

endpackage

// File: rtl/alu16_addsub.sv
`timescale 1ns/1ps
module alu16_addsub #(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o
);
   logic [W-1:0] b_eff;

   assign b_eff = sub_i ? ~b_i : b_i;

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = sub_i;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i]  = a_i[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1]   = (a_i[i] & b_eff[i]) | (cy[i] & (a_i[i] ^ b_eff[i]));
         end
         assign carry_o = cy[W];
      end else begin : g_wide
         logic [W:0] wide;
         assign wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
         assign sum_o   = wide[W-1:0];
         assign carry_o = wide[W];
      end
   endgenerate

   // signed overflow: operands of equal sign, result of the other sign
   assign ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);

endmodule

// File: rtl/alu16_asr.sv
`timescale 1ns/1ps
module alu16_asr #(
   parameter int W      = 16,
   parameter int AMT_W  = 8,
   parameter bit BARREL = 1'b1
) (
   input  logic [W-1:0]     val_i,
   input  logic [AMT_W-1:0] amt_i,
   output logic [W-1:0]     res_o,
   output logic             carry_o,
   output logic             zero_amt_o
);
   localparam int SH_W = $clog2(W);

   logic [SH_W-1:0] sh;
   logic            big;
   logic [W-1:0]    shifted;
   logic [SH_W-1:0] pick;

   assign sh         = amt_i[SH_W-1:0];
   assign big        = (amt_i >= AMT_W'(W));
   assign zero_amt_o = (amt_i == '0);
   assign pick       = sh - SH_W'(1);

   generate
      if (BARREL) begin : g_barrel
         logic [W-1:0] stage [SH_W+1];
         assign stage[0] = val_i;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = sh[k]
               ? {{STEP{val_i[W-1]}}, stage[k][W-1:STEP]}
               : stage[k];
         end
         assign shifted = stage[SH_W];
      end else begin : g_behav
         assign shifted = W'($signed(val_i) >>> sh);
      end
   endgenerate

   always_comb begin
      if (zero_amt_o) begin
         res_o   = val_i;
         carry_o = 1'b0;           // not used: C is held for a zero amount
      end else if (big) begin
         res_o   = {W{val_i[W-1]}};
         carry_o = val_i[W-1];
      end else begin
         res_o   = shifted;
         carry_o = val_i[pick];
      end
   end

endmodule

// File: rtl/alu16_ctl.sv
`timescale 1ns/1ps
module alu16_ctl
   import alu16_pkg::*;
(
   input  logic      [3:0] op_i,
   input  logic            shift_zero_i,
   output flag_ctl_t       ctl_o
);
   always_comb begin
      ctl_o = '{wr: 1'b0, upd: 4'b0000, force_n0: 1'b0, csrc: CSRC_HOLD};
      case (op_i)
         OP_ADD, OP_NEG: begin
            ctl_o.wr   = 1'b1;
            ctl_o.upd  = 4'b1111;
            ctl_o.csrc = CSRC_ADDER;
         end
         OP_CMP: begin
            ctl_o.upd  = 4'b1111;
            ctl_o.csrc = CSRC_ADDER;
         end
         OP_AND, OP_EOR, OP_MOV: begin
            ctl_o.wr  = 1'b1;
            ctl_o.upd = 4'b1100;
         end
         OP_TST: begin
            ctl_o.upd = 4'b1100;
         end
         OP_ASR: begin
            ctl_o.wr   = 1'b1;
            ctl_o.upd  = shift_zero_i ? 4'b1100 : 4'b1110;
            ctl_o.csrc = CSRC_SHIFT;
         end
         OP_MOVI: begin
            ctl_o.wr       = 1'b1;
            ctl_o.upd      = 4'b1100;
            ctl_o.force_n0 = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/alu16_core.sv
`timescale 1ns/1ps
module alu16_core
   import alu16_pkg::*;
#(
   parameter int W      = 16,
   parameter int AMT_W  = 8,
   parameter bit RIPPLE = 1'b0,
   parameter bit BARREL = 1'b1
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [3:0]   flags_i,
   output logic [W-1:0] result_o,
   output logic [3:0]   flags_o,
   output logic         wr_en_o
);
   // elaboration checks
   if (W < 4 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("alu16_core: W must be a power of two, at least 4");
   end
   if ((1 << AMT_W) <= W || AMT_W > W) begin : g_bad_amt
      $error("alu16_core: AMT_W must reach W and fit in the operand");
   end

   logic [W-1:0]     add_a;
   logic             add_sub;
   logic [W-1:0]     add_sum;
   logic             add_c, add_v;
   logic [W-1:0]     sh_res;
   logic             sh_c, sh_zero;
   flag_ctl_t        ctl;
   logic [3:0]       fresh;

   assign add_a   = (op_i == OP_NEG) ? '0 : a_i;
   assign add_sub = (op_i == OP_NEG) || (op_i == OP_CMP);

   alu16_addsub #(.W(W), .RIPPLE(RIPPLE)) u_addsub (
      .a_i     (add_a),
      .b_i     (b_i),
      .sub_i   (add_sub),
      .sum_o   (add_sum),
      .carry_o (add_c),
      .ovf_o   (add_v)
   );

   alu16_asr #(.W(W), .AMT_W(AMT_W), .BARREL(BARREL)) u_asr (
      .val_i      (a_i),
      .amt_i      (b_i[AMT_W-1:0]),
      .res_o      (sh_res),
      .carry_o    (sh_c),
      .zero_amt_o (sh_zero)
   );

   alu16_ctl u_ctl (
      .op_i         (op_i),
      .shift_zero_i (sh_zero),
      .ctl_o        (ctl)
   );

   always_comb begin
      case (op_i)
         OP_ADD, OP_NEG, OP_CMP: result_o = add_sum;
         OP_AND, OP_TST:         result_o = a_i & b_i;
         OP_EOR:                 result_o = a_i ^ b_i;
         OP_ASR:                 result_o = sh_res;
         OP_MOV, OP_MOVI:        result_o = b_i;
         default:                result_o = '0;
      endcase
   end

   always_comb begin
      fresh[FLAG_N] = ctl.force_n0 ? 1'b0 : result_o[W-1];
      fresh[FLAG_Z] = (result_o == '0);
      case (ctl.csrc)
         CSRC_ADDER: fresh[FLAG_C] = add_c;
         CSRC_SHIFT: fresh[FLAG_C] = sh_c;
         default:    fresh[FLAG_C] = flags_i[FLAG_C];
      endcase
      fresh[FLAG_V] = add_v;
   end

   for (genvar f = 0; f < 4; f++) begin : g_flag
      assign flags_o[f] = ctl.upd[f] ? fresh[f] : flags_i[f];
   end

   assign wr_en_o = ctl.wr;

endmodule

// File: rtl/alu16_core_chk.sv
`timescale 1ns/1ps
module alu16_core_chk
   import alu16_pkg::*;
#(
   parameter int W     = 16,
   parameter int AMT_W = 8
) (
   input logic [3:0]   op_i,
   input logic [W-1:0] a_i,
   input logic [W-1:0] b_i,
   input logic [3:0]   flags_i,
   input logic [W-1:0] result_o,
   input logic [3:0]   flags_o,
   input logic         wr_en_o
);
   logic nz_op, logic_op, unassigned;

   assign nz_op      = (op_i <= OP_MOV);
   assign logic_op   = (op_i == OP_AND) || (op_i == OP_EOR) ||
                       (op_i == OP_TST) || (op_i == OP_MOV);
   assign unassigned = (op_i > OP_MOVI);

   always_comb begin
      if (nz_op) begin
         p_n_from_result_r1: assert (flags_o[FLAG_N] == result_o[W-1])
            else $error("N does not follow result bit");
         p_z_from_result_r1: assert (flags_o[FLAG_Z] == (result_o == '0))
            else $error("Z does not follow result");
      end
      if (logic_op) begin
         p_logic_keeps_cv_r4: assert (flags_o[1:0] == flags_i[1:0])
            else $error("logic op changed C or V");
      end
      if (op_i == OP_ASR && b_i[AMT_W-1:0] == '0) begin
         p_asr_zero_holds_r6: assert (result_o == a_i && flags_o[FLAG_C] == flags_i[FLAG_C])
            else $error("zero shift changed value or C");
      end
      if (op_i == OP_ASR) begin
         p_asr_keeps_v_r8: assert (flags_o[FLAG_V] == flags_i[FLAG_V])
            else $error("shift changed V");
      end
      if (op_i == OP_MOVI) begin
         p_movi_n_clear_r9: assert (!flags_o[FLAG_N] && flags_o[1:0] == flags_i[1:0])
            else $error("immediate move flag rule broken");
      end
      if (op_i == OP_CMP || op_i == OP_TST) begin
         p_no_write_on_compare_r10: assert (!wr_en_o)
            else $error("compare or test wrote the destination");
      end
      if (unassigned) begin
         p_unassigned_inert_r11: assert (!wr_en_o && flags_o == flags_i && result_o == '0)
            else $error("unassigned code had an effect");
      end
   end
endmodule

bind alu16_core alu16_core_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
   .op_i     (op_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .flags_i  (flags_i),
   .result_o (result_o),
   .flags_o  (flags_o),
   .wr_en_o  (wr_en_o)
);

// File: tb/alu16_core_test.sv
`timescale 1ns/1ps
module alu16_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op;
   logic [15:0] a, b;
   logic [3:0]  fin;
   logic [15:0] res;
   logic [3:0]  fout;
   logic        we;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   alu16_core uut (
      .op_i(op), .a_i(a), .b_i(b), .flags_i(fin),
      .result_o(res), .flags_o(fout), .wr_en_o(we)
   );

   // reference model, flags {N,Z,C,V}
   function automatic logic [20:0] model(input logic [3:0] o, input logic [15:0] x,
                                         input logic [15:0] y, input logic [3:0] f);
      logic [15:0] r;
      logic [16:0] w;
      logic n, z, c, v, wr;
      n = f[3]; z = f[2]; c = f[1]; v = f[0]; r = 16'h0; wr = 1'b0;
      case (o)
         4'd0: begin   // R2
            w = {1'b0, x} + {1'b0, y}; r = w[15:0]; c = w[16];
            v = (x[15] == y[15]) && (r[15] != x[15]);
            n = r[15]; z = (r == 0); wr = 1'b1;
         end
         4'd5, 4'd6: begin   // R3
            logic [15:0] m;
            m = (o == 4'd5) ? 16'h0 : x;
            w = {1'b0, m} - {1'b0, y}; r = w[15:0]; c = !w[16];
            v = (m[15] != y[15]) && (r[15] != m[15]);
            n = r[15]; z = (r == 0); wr = (o == 4'd5);
         end
         4'd1, 4'd4: begin r = x & y; n = r[15]; z = (r == 0); wr = (o == 4'd1); end
         4'd2: begin r = x ^ y; n = r[15]; z = (r == 0); wr = 1'b1; end
         4'd7: begin r = y; n = r[15]; z = (r == 0); wr = 1'b1; end
         4'd3: begin   // R5 R6 R7 R8: shift one place at a time
            r = x;
            for (int i = 0; i < int'(y[7:0]); i++) begin
               c = r[0];
               r = {r[15], r[15:1]};
            end
            n = r[15]; z = (r == 0); wr = 1'b1;
         end
         4'd8: begin r = y; n = 1'b0; z = (r == 0); wr = 1'b1; end
         default: ;
      endcase
      return {r, n, z, c, v, wr};
   endfunction

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0: return "R2";
         4'd5, 4'd6: return "R3";
         4'd1, 4'd2, 4'd4, 4'd7: return "R4";
         4'd3: return "R5";
         4'd8: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic apply(input string tag, input logic [3:0] o, input logic [15:0] x,
                        input logic [15:0] y, input logic [3:0] f);
      logic [20:0] exp;
      @(negedge clk);
      op = o; a = x; b = y; fin = f;
      #1;
      exp = model(o, x, y, f);
      n_checks++;
      if (res !== exp[20:5] || fout !== exp[4:1] || we !== exp[0]) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h f=%b: got res=%h flags=%b we=%b, expected res=%h flags=%b we=%b",
                  tag, o, x, y, f, res, fout, we, exp[20:5], exp[4:1], exp[0]);
      end
   endtask

   initial begin
      op = 4'd15; a = '0; b = '0; fin = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // idle state: unassigned code, no write, flags pass through (R11, R10)
      apply("R11", 4'd15, 16'h1234, 16'h5678, 4'b1010);
      // R1 R2: signed overflow into negative, carry with zero result
      apply("R2", 4'd0, 16'h7FFF, 16'h0001, 4'b0000);
      apply("R1", 4'd0, 16'hFFFF, 16'h0001, 4'b0000);
      // R3: equal compare, borrowing compare, negate corners
      apply("R3", 4'd6, 16'h0042, 16'h0042, 4'b0000);
      apply("R3", 4'd6, 16'h0000, 16'h0001, 4'b0111);
      apply("R3", 4'd5, 16'h5555, 16'h0000, 4'b0000);
      apply("R3", 4'd5, 16'h0000, 16'h8000, 4'b0000);
      // R4: logic ops keep C and V
      apply("R4", 4'd1, 16'hF0F0, 16'h0F0F, 4'b0011);
      apply("R4", 4'd4, 16'h8001, 16'h8000, 4'b0011);
      // R5 R6 R7 R8: shift amounts at the edges
      apply("R6", 4'd3, 16'h8421, 16'h0000, 4'b0011);
      apply("R6", 4'd3, 16'h8421, 16'h0100, 4'b0010);
      apply("R5", 4'd3, 16'h8001, 16'h0001, 4'b0001);
      apply("R5", 4'd3, 16'h4000, 16'h000F, 4'b0011);
      apply("R7", 4'd3, 16'h8000, 16'h0010, 4'b0001);
      apply("R7", 4'd3, 16'h7FFF, 16'h00FF, 4'b0011);
      apply("R8", 4'd3, 16'h0003, 16'h0002, 4'b0001);
      // R9: immediate move
      apply("R9", 4'd8, 16'hAAAA, 16'h0000, 4'b1011);
      apply("R9", 4'd8, 16'hAAAA, 16'h00FF, 4'b1011);
      // R10: write strobe
      apply("R10", 4'd4, 16'hFFFF, 16'hFFFF, 4'b0000);
      apply("R10", 4'd9, 16'hFFFF, 16'hFFFF, 4'b0000);
      // constrained random
      void'($urandom(32'd4711));
      for (int i = 0; i < 3000; i++) begin
         logic [3:0]  o;
         logic [15:0] x, y;
         o = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 3) != 0) o = 4'($urandom_range(0, 8));
         x = 16'($urandom);
         y = 16'($urandom);
         if (o == 4'd3 && $urandom_range(0, 1) == 1) y = {8'($urandom), 8'($urandom_range(0, 20))};
         apply(req_of(o), o, x, y, 4'($urandom));
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      finished = 1'b1;
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule